// File: doc/BRIEF.md
# Slow SPI Byte-Exchange Register

This block is a single-address special function register that lets a small soft processor exchange one byte at a time with a slow serial peripheral, such as a resistive touch-panel controller. When the processor writes a byte with the load strobe asserted, the block latches the byte and starts a full-duplex serial exchange. It drives the serial clock and the outgoing data line, and it captures the incoming data line at the same time.

The serial clock rests high when idle. Every bit is stretched over a fixed number of system clocks, 32 by default, so the serial rate stays low enough for the slow peripheral and no second clock is needed. On each bit the clock is low for the first half of the window and high for the second half. Outgoing data changes on falling clock edges. Incoming data is captured on rising clock edges.

A processor read of the same register returns a 16-bit word:

- Bit 15 is a busy flag.
- Bits 14:8 read as zero.
- Bits 7:0 hold the byte received by the last completed exchange.

Software polls the busy flag and then reads the received byte.

Top module: `slow_spi_sfr`

## Requirements
- R1: A load pulse while idle latches `wdata` and sets `rdata[15]` (busy) in the next cycle.
- R2: Busy stays high for exactly DATA_W*BIT_CYCLES = 256 system clock cycles per exchange, then returns to 0.
- R3: `sck` is high whenever the block is idle. During an exchange each bit window holds `sck` low for 16 cycles and then high for 16 cycles. This gives exactly 8 rising edges per exchange, and `sck` stays high afterwards.
- R4: `sdo` presents the written byte most significant bit first. `sdo` changes only at falling `sck` edges and never while `sck` stays high.
- R5: `sdi` is captured at each rising `sck` edge, and the first captured bit becomes bit 7 of the received byte.
- R6: `rdata[7:0]` keeps the previous received byte throughout an exchange. It changes only in the cycle busy falls, when it takes the new byte.
- R7: `rdata[15]` is the busy flag (1 = exchange in progress, 0 = idle), and `rdata[14:8]` always reads 0.
- R8: A load pulse while busy is ignored. The ongoing exchange keeps its data, its timing and its length.
- R9: After reset the block is idle with `rdata` = 0, `sck` = 1 and `sdo` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Write strobe that starts an exchange |
| wdata | input | 8 | Byte to transmit |
| rdata | output | 16 | Read word: busy in bit 15, received byte in 7:0 |
| sdi | input | 1 | Serial data from the peripheral |
| sdo | output | 1 | Serial data to the peripheral |
| sck | output | 1 | Serial clock, idle high |

## Verification
On every cycle the assertions check four things:

- Busy is raised after an idle load.
- The busy window is exactly 256 cycles long, measured with a counter in the checker.
- The serial clock is high when idle, and `sdo` is steady while `sck` stays high.
- The upper read bits are zero, and the received byte changes only when busy falls.

The received value, the MSB-first bit order on both lines, the count of eight clock pulses, the rejection of a load during busy and back-to-back exchanges can only be shown by the bench's scenarios. In those scenarios a modelled peripheral shifts known bytes in and records what it receives.

// File: rtl/slow_spi_pkg.sv
package slow_spi_pkg;
  typedef enum logic {XFER_IDLE = 1'b0, XFER_RUN = 1'b1} xfer_state_t;

  function automatic int unsigned xfer_cycles(input int unsigned bits, input int unsigned per_bit);
    return bits * per_bit;
  endfunction
endpackage

// File: rtl/slow_spi_timer.sv
module slow_spi_timer #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned BIT_CYCLES = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic sample_tick,
  output logic shift_tick,
  output logic done_tick,
  output logic sck
);
  localparam int unsigned HALF  = BIT_CYCLES / 2;
  localparam int unsigned PH_W  = $clog2(BIT_CYCLES);
  localparam int unsigned BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(BIT_CYCLES - 1);
  localparam logic [PH_W-1:0]  PH_RISE   = PH_W'(HALF - 1);
  localparam logic [BIT_W-1:0] BIT_FINAL = BIT_W'(DATA_W - 1);

  logic [PH_W-1:0]  phase_q;
  logic [BIT_W-1:0] bit_q;
  logic             sck_q;
  logic             at_end;
  logic             last_bit;

  assign at_end      = run && (phase_q == PH_LAST);
  assign last_bit    = (bit_q == BIT_FINAL);
  assign sample_tick = run && (phase_q == PH_RISE);
  assign shift_tick  = at_end && !last_bit;
  assign done_tick   = at_end && last_bit;
  assign sck         = sck_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      bit_q   <= '0;
      sck_q   <= 1'b1;
    end else if (start) begin
      phase_q <= '0;
      bit_q   <= '0;
      sck_q   <= 1'b0;
    end else if (run) begin
      if (at_end) begin
        phase_q <= '0;
        if (!last_bit) begin
          bit_q <= bit_q + 1'b1;
          sck_q <= 1'b0;
        end
      end else begin
        phase_q <= phase_q + 1'b1;
        if (phase_q == PH_RISE) sck_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/slow_spi_shifter.sv
module slow_spi_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              sample_tick,
  input  logic              shift_tick,
  input  logic              done_tick,
  input  logic              sdi,
  output logic              sdo,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] rx_q;
  logic [DATA_W-1:0] held_q;
  logic              sdo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q  <= '0;
      sdo_q <= 1'b0;
    end else if (start) begin
      tx_q  <= tx_byte;
      sdo_q <= tx_byte[MSB];
    end else if (shift_tick) begin
      tx_q  <= tx_q << 1;
      sdo_q <= tx_q[MSB-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rx_q <= '0;
    else if (sample_tick) rx_q <= {rx_q[MSB-1:0], sdi};
  end

  always_ff @(posedge clk) begin
    if (rst) held_q <= '0;
    else if (done_tick) held_q <= rx_q;
  end

  assign sdo     = sdo_q;
  assign rx_byte = held_q;
endmodule

// File: rtl/slow_spi_sfr.sv
module slow_spi_sfr #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned BIT_CYCLES = 32,
  parameter int unsigned WORD_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  input  logic              sdi,
  output logic              sdo,
  output logic              sck
);
  import slow_spi_pkg::*;

  localparam int unsigned PAD_W = WORD_W - DATA_W - 1;

  xfer_state_t       state_q;
  logic              accept;
  logic              running;
  logic              sample_tick;
  logic              shift_tick;
  logic              done_tick;
  logic [DATA_W-1:0] rx_byte;

  assign running = (state_q == XFER_RUN);
  assign accept  = load && !running;

  always_ff @(posedge clk) begin
    if (rst) state_q <= XFER_IDLE;
    else if (accept) state_q <= XFER_RUN;
    else if (done_tick) state_q <= XFER_IDLE;
  end

  slow_spi_timer #(.DATA_W(DATA_W), .BIT_CYCLES(BIT_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(accept), .run(running),
    .sample_tick(sample_tick), .shift_tick(shift_tick),
    .done_tick(done_tick), .sck(sck)
  );

  slow_spi_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk(clk), .rst(rst), .start(accept), .tx_byte(wdata),
    .sample_tick(sample_tick), .shift_tick(shift_tick),
    .done_tick(done_tick), .sdi(sdi), .sdo(sdo), .rx_byte(rx_byte)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign rdata = {running, {PAD_W{1'b0}}, rx_byte};
    end else begin : g_nopad
      assign rdata = {running, rx_byte};
    end
  endgenerate
endmodule

// File: rtl/slow_spi_sfr_checker.sv
module slow_spi_sfr_checker #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned BIT_CYCLES = 32,
  parameter int unsigned WORD_W     = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              load,
  input logic [WORD_W-1:0] rdata,
  input logic              sdo,
  input logic              sck
);
  localparam int unsigned TOTAL = slow_spi_pkg::xfer_cycles(DATA_W, BIT_CYCLES);
  localparam int unsigned CNT_W = $clog2(TOTAL + 2);

  logic busy;
  logic [CNT_W-1:0] busy_run_q;
  assign busy = rdata[WORD_W-1];

  always_ff @(posedge clk) begin
    if (rst) busy_run_q <= '0;
    else if (busy) busy_run_q <= busy_run_q + 1'b1;
    else busy_run_q <= '0;
  end

  p_load_starts_r1: assert property (@(posedge clk) disable iff (rst)
    (load && !busy) |=> busy);

  p_busy_length_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_run_q == CNT_W'(TOTAL)));

  p_idle_sck_high_r3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> sck);

  p_sdo_steady_r4: assert property (@(posedge clk) disable iff (rst)
    (sck && $past(sck)) |-> $stable(sdo));

  p_rx_update_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(rdata[DATA_W-1:0]) |-> $fell(busy));

  p_pad_zero_r7: assert property (@(posedge clk) disable iff (rst)
    rdata[WORD_W-2:DATA_W] == '0);
endmodule

bind slow_spi_sfr slow_spi_sfr_checker #(
  .DATA_W(DATA_W), .BIT_CYCLES(BIT_CYCLES), .WORD_W(WORD_W)
) u_checker (
  .clk(clk), .rst(rst), .load(load), .rdata(rdata), .sdo(sdo), .sck(sck)
);

// File: tb/slow_spi_sfr_bench.sv
module slow_spi_sfr_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [15:0] rdata;
  logic        sdi = 1'b0;
  logic        sdo;
  logic        sck;

  int compared = 0;
  int mismatched = 0;
  int rises = 0;
  int rise_base = 0;
  logic [7:0] peer_byte = 8'h00;
  logic [7:0] heard = 8'h00;

  always #2 clk = ~clk;

  slow_spi_sfr u_slow_spi_sfr (
    .clk(clk), .rst(rst), .load(load), .wdata(wdata),
    .rdata(rdata), .sdi(sdi), .sdo(sdo), .sck(sck)
  );

  // peripheral model: capture sdo on rising sck, present next sdi bit on falling sck
  always @(posedge sck) begin
    heard = {heard[6:0], sdo};
    rises = rises + 1;
  end

  always @(negedge sck) begin
    if ((rises - rise_base) < 8)
      sdi = peer_byte[3'(7 - (rises - rise_base))];
  end

  task automatic check(input string req, input longint actual, input longint expected);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 rdata after reset", rdata, 0);
    check("R9 sck after reset", sck, 1);
    check("R9 sdo after reset", sdo, 0);
    check("R3 sck idle high", sck, 1);
  endtask

  task automatic t_exchange(input logic [7:0] tx, input logic [7:0] peer, input bit poke);
    logic [7:0] prev;
    int n;
    int low_cnt;
    prev = rdata[7:0];
    peer_byte = peer;
    rise_base = rises;
    @(negedge clk);
    load = 1'b1;
    wdata = tx;
    @(negedge clk);
    load = 1'b0;
    wdata = 8'h00;
    check("R1 busy after load", rdata[15], 1);
    check("R7 pad bits zero", rdata[14:8], 0);
    n = 0;
    low_cnt = 0;
    while (rdata[15] && n < 400) begin
      n++;
      if (n <= 32 && !sck) low_cnt++;
      if (poke && n == 40) begin load = 1'b1; wdata = ~tx; end
      if (poke && n == 41) begin load = 1'b0; wdata = 8'h00; end
      if (n == 128) check("R6 rx held during exchange", rdata[7:0], prev);
      @(negedge clk);
    end
    check("R2 busy cycle count", n, 256);
    check("R3 first bit low half", low_cnt, 16);
    check("R3 rising edges", rises - rise_base, 8);
    check("R3 sck high after", sck, 1);
    check("R4 bytes seen on sdo", heard, tx);
    check("R5 received byte", rdata[7:0], peer);
    check("R7 busy clear", rdata[15], 0);
    if (poke) check("R8 load during busy ignored", heard, tx);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    t_reset();
    t_exchange(8'hA5, 8'h3C, 1'b0);
    t_exchange(8'h00, 8'hFF, 1'b0);
    t_exchange(8'hFF, 8'h00, 1'b0);
    t_exchange(8'h81, 8'h5A, 1'b1);
    t_exchange(8'h7E, 8'hC3, 1'b0);
    repeat (5) @(negedge clk);
    check("R3 idle sck high at end", sck, 1);
    check("R7 idle pad zero", rdata[14:8], 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule